// File: doc/BRIEF.md
# Link Status Register with Bandwidth-Change Detection

This block is a 16-bit status register for one serial link port. It turns events from the physical layer and from software into two sticky flags that software clears by writing 1. The first flag records that the far end changed the link speed or width on its own initiative. The second flag records a change made to manage bandwidth: a change made for reliability, a change the far end did not mark as autonomous, or a retrain request from software. The register also reports whether the data link layer is active and shows a fixed common-reference-clock indication.

The autonomous flag can also be set from the received training stream. Each ordered set arrives with a valid strobe, a flag that marks it as a training set, and the autonomous-change bit it carries. A run of eight training sets in a row, each with the autonomous bit, sets the flag. Any other ordered set breaks the run. Cycles with no valid ordered set do not break it. While the link-down indication is high, every event is dropped and the run count restarts.

Software clears the flags by writing 1 to them through a write port that has a byte address, two byte enables and 16 data bits. The whole register word is always visible on the read data output, and each flag also has an output of its own.

Top module: `lnk_status_reg`

## Requirements
- R1: After synchronous reset the read word is 16'h1000, with bits 15, 14 and 13 at 0, bit 12 at 1 and bits 11:0 at 0.
- R2: Bit 15 is set at the clock edge that accepts the eighth qualifying ordered set in a row. A qualifying set has `os_valid`, `os_is_ts` and `os_auto` all high. Seven or fewer in a row leave bit 15 clear. Cycles with `os_valid` low do not break the run.
- R3: A valid ordered set that is not qualifying restarts the run. This covers a set with `os_is_ts` low and a set with `os_auto` low. Eight further qualifying sets are then needed to set bit 15.
- R4: A physical-layer change report (`chg_valid`) with `chg_auto` high sets bit 15 and leaves bit 14 alone. With `chg_auto` low it sets bit 14 and leaves bit 15 alone.
- R5: A `retrain_wr` pulse sets bit 14 at the next clock edge.
- R6: A `fix_chg` pulse, which marks a hardware change made for reliability, sets bit 14 at the next clock edge.
- R7: A write to bit 15 or bit 14 clears that bit when all of the following hold: `wr_en` is high, `wr_addr` equals the register address (default 12'h0B2), `wr_be[1]` is high and the data bit is 1. A data bit of 0, a different address, or `wr_be[1]` low leaves the bit unchanged. Without a clearing write, a set bit stays set.
- R8: When a hardware set and a clearing write hit the same bit in the same cycle, the bit ends up 1.
- R9: While `dl_down` is high, no source sets bit 15 or bit 14. A qualifying ordered set is not counted, and the run restarts from zero.
- R10: Bit 13 shows `dl_active` as registered at the previous edge when the data-link-active report is enabled, and reads 0 when it is disabled. Bit 12 always reads 1 and bits 11:0 always read 0. Writes never change bits 13:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_valid | input | 1 | An ordered set is received this cycle |
| os_is_ts | input | 1 | The ordered set is a training set |
| os_auto | input | 1 | The ordered set carries the autonomous-change bit |
| chg_valid | input | 1 | Physical layer reports a change of speed or width started by the far end |
| chg_auto | input | 1 | The reported change was marked autonomous |
| fix_chg | input | 1 | Hardware changed speed or width to recover an unreliable link |
| retrain_wr | input | 1 | Software wrote 1 to the retrain control |
| dl_active | input | 1 | Data link layer is in its active state |
| dl_down | input | 1 | Port is in the link-down state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (12) | Byte address of the write |
| wr_be | input | 2 | Byte enables, where bit 1 covers bits 15:8 |
| wr_data | input | 16 | Write data; a 1 clears the matching sticky bit |
| rd_data | output | 16 | Current register word |
| sts_auto_bw | output | 1 | Bit 15: autonomous bandwidth change seen |
| sts_bw_mgmt | output | 1 | Bit 14: bandwidth-management change seen |
| sts_link_up | output | 1 | Bit 13: data link layer active |

## Verification
The collision that matters is a hardware set landing in the same cycle as a clearing write to the same bit. The bench provokes it with a change report, a retrain pulse and the eighth ordered set of a run, each timed exactly on the write cycle. It expects the set to win and, in the same cycle, the bit without a set to clear. A pseudo-random sweep then mixes all sources with writes at random addresses and enables, plus link-down cycles. It tracks the expected word arithmetically from the requirements and compares it with the read word after every edge.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  typedef struct packed {
    logic        auto_bw;
    logic        bw_mgmt;
    logic        link_up;
    logic        com_clk;
    logic [11:0] rsvd;
  } lsr_word_t;

  localparam int unsigned WORD_W = $bits(lsr_word_t);
  localparam int unsigned NUM_STICKY = 2;

endpackage

// File: rtl/lsr_run_detect.sv
module lsr_run_detect #(
  parameter int unsigned RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic os_valid,
  input  logic os_qual,
  output logic hit
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt <= '0;
    end else if (os_valid) begin
      if (!os_qual)
        cnt <= '0;
      else if (cnt != FULL)
        cnt <= cnt + 1'b1;
    end
  end

  assign hit = os_valid && os_qual && !flush && (cnt == LAST);
endmodule

// File: rtl/lsr_sticky_w1c.sv
module lsr_sticky_w1c (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (set)
      q <= 1'b1;
    else if (clr)
      q <= 1'b0;
  end
endmodule

// File: rtl/lsr_link_track.sv
module lsr_link_track (
  input  logic clk,
  input  logic rst,
  input  logic dl_active,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else
      q <= dl_active;
  end
endmodule

// File: rtl/lnk_status_reg.sv
module lnk_status_reg #(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h0B2,
  parameter int unsigned RUN_LEN    = 8,
  parameter bit          DLL_REPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_valid,
  input  logic              os_is_ts,
  input  logic              os_auto,
  input  logic              chg_valid,
  input  logic              chg_auto,
  input  logic              fix_chg,
  input  logic              retrain_wr,
  input  logic              dl_active,
  input  logic              dl_down,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_be,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              sts_auto_bw,
  output logic              sts_bw_mgmt,
  output logic              sts_link_up
);
  import lsr_pkg::*;

  logic run_hit;
  logic wr_hit;
  logic [NUM_STICKY-1:0] set_v;
  logic [NUM_STICKY-1:0] clr_v;
  logic [NUM_STICKY-1:0] q_v;
  logic link_q;
  lsr_word_t word;

  lsr_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .flush    (dl_down),
    .os_valid (os_valid),
    .os_qual  (os_is_ts && os_auto),
    .hit      (run_hit)
  );

  assign wr_hit = wr_en && (wr_addr == REG_ADDR) && wr_be[1];

  // index 1 = autonomous flag (bit 15), index 0 = management flag (bit 14)
  assign set_v[1] = !dl_down && (run_hit || (chg_valid && chg_auto));
  assign set_v[0] = !dl_down && (retrain_wr || fix_chg || (chg_valid && !chg_auto));
  assign clr_v    = {wr_hit && wr_data[15], wr_hit && wr_data[14]};

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    lsr_sticky_w1c u_bit (
      .clk (clk),
      .rst (rst),
      .set (set_v[i]),
      .clr (clr_v[i]),
      .q   (q_v[i])
    );
  end

  if (DLL_REPORT) begin : g_link
    lsr_link_track u_link (
      .clk       (clk),
      .rst       (rst),
      .dl_active (dl_active),
      .q         (link_q)
    );
  end else begin : g_nolink
    assign link_q = 1'b0;
  end

  always_comb begin
    word         = '0;
    word.auto_bw = q_v[1];
    word.bw_mgmt = q_v[0];
    word.link_up = link_q;
    word.com_clk = 1'b1;
  end

  assign rd_data     = word;
  assign sts_auto_bw = q_v[1];
  assign sts_bw_mgmt = q_v[0];
  assign sts_link_up = link_q;
endmodule

// File: rtl/lnk_status_chk.sv
module lnk_status_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h0B2,
  parameter bit          DLL_REPORT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              chg_valid,
  input logic              chg_auto,
  input logic              retrain_wr,
  input logic              dl_active,
  input logic              dl_down,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        wr_be,
  input logic [15:0]       wr_data,
  input logic [15:0]       rd_data
);
  logic clr_hit;
  assign clr_hit = wr_en && (wr_addr == REG_ADDR) && wr_be[1];

  p_reset_word_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_data == 16'h1000);

  p_fixed_bits_r10: assert property (@(posedge clk) disable iff (rst)
    rd_data[12] && rd_data[11:0] == 12'h000);

  p_link_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_data[13] == (DLL_REPORT ? $past(dl_active) : 1'b0));

  p_ro_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (|wr_be) && wr_data[13:0] != 14'h0) |=> rd_data[12:0] == 13'h1000);

  p_chg_auto_r4: assert property (@(posedge clk) disable iff (rst)
    (!dl_down && chg_valid && chg_auto) |=> rd_data[15]);

  p_chg_mgmt_r4: assert property (@(posedge clk) disable iff (rst)
    (!dl_down && chg_valid && !chg_auto) |=> rd_data[14]);

  p_retrain_r5: assert property (@(posedge clk) disable iff (rst)
    (!dl_down && retrain_wr) |=> rd_data[14]);

  p_down_auto_r9: assert property (@(posedge clk) disable iff (rst)
    (dl_down && !rd_data[15]) |=> !rd_data[15]);

  p_down_mgmt_r9: assert property (@(posedge clk) disable iff (rst)
    (dl_down && !rd_data[14]) |=> !rd_data[14]);

  p_w1c_auto_r7: assert property (@(posedge clk) disable iff (rst)
    (dl_down && clr_hit && wr_data[15]) |=> !rd_data[15]);

  p_sticky_auto_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_data[15] && !wr_en) |=> rd_data[15]);

  p_sticky_mgmt_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_data[14] && !wr_en) |=> rd_data[14]);
endmodule

bind lnk_status_reg lnk_status_chk #(
  .ADDR_W    (ADDR_W),
  .REG_ADDR  (REG_ADDR),
  .DLL_REPORT(DLL_REPORT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chg_valid (chg_valid),
  .chg_auto  (chg_auto),
  .retrain_wr(retrain_wr),
  .dl_active (dl_active),
  .dl_down   (dl_down),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_be     (wr_be),
  .wr_data   (wr_data),
  .rd_data   (rd_data)
);

// File: tb/lnk_status_reg_tb.sv
module lnk_status_reg_tb;
  localparam int CLK_P = 10;
  localparam logic [11:0] RA = 12'h0B2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_valid = 0, os_is_ts = 0, os_auto = 0;
  logic chg_valid = 0, chg_auto = 0, fix_chg = 0, retrain_wr = 0;
  logic dl_active = 0, dl_down = 0;
  logic wr_en = 0;
  logic [11:0] wr_addr = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic sts_auto_bw, sts_bw_mgmt, sts_link_up;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lnk_status_reg u_dut (
    .clk(clk), .rst(rst),
    .os_valid(os_valid), .os_is_ts(os_is_ts), .os_auto(os_auto),
    .chg_valid(chg_valid), .chg_auto(chg_auto), .fix_chg(fix_chg),
    .retrain_wr(retrain_wr), .dl_active(dl_active), .dl_down(dl_down),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .sts_auto_bw(sts_auto_bw), .sts_bw_mgmt(sts_bw_mgmt),
    .sts_link_up(sts_link_up)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    os_valid = 0; os_is_ts = 0; os_auto = 0;
    chg_valid = 0; chg_auto = 0; fix_chg = 0; retrain_wr = 0;
    wr_en = 0; wr_be = 0; wr_data = 0; wr_addr = RA;
  endtask

  task automatic send_os(input logic ts, input logic au);
    os_valid = 1; os_is_ts = ts; os_auto = au;
    tick();
    os_valid = 0; os_is_ts = 0; os_auto = 0;
  endtask

  task automatic send_qual(input int n);
    for (int i = 0; i < n; i++) send_os(1, 1);
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
    tick();
    idle();
  endtask

  // clear both flags and restart the run with a breaking ordered set
  task automatic clean();
    send_os(0, 0);
    wr(RA, 2'b11, 16'hC000);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic e15, e14, edl;
    int run;
    logic ov, ts, au, cv, ca, fx, rt, dd, da, we;
    logic [11:0] ad;
    logic [1:0] be;
    logic [15:0] wd;
    logic s15, s14, c15, c14;

    idle();
    @(negedge clk);
    tick(); tick();
    rst = 0;
    tick();
    // R1 reset value
    chk("R1 reset word", rd_data, 16'h1000);

    // R10 link bit follows dl_active, read-only bits ignore writes
    dl_active = 1;
    tick();
    chk("R10 link up", {15'b0, sts_link_up}, 16'h0001);
    wr(RA, 2'b11, 16'h3FFF);
    chk("R10 ro write", rd_data, 16'h3000);
    dl_active = 0;
    tick();
    chk("R10 link down", rd_data, 16'h1000);

    // R2 run length sweep
    for (int n = 0; n <= 10; n++) begin
      clean();
      send_qual(n);
      chk($sformatf("R2 run %0d", n), {15'b0, sts_auto_bw}, {15'b0, n >= 8});
    end
    // R2 idle gaps do not break the run
    clean();
    send_qual(4);
    tick(); tick(); tick();
    send_qual(4);
    chk("R2 gaps keep run", {15'b0, sts_auto_bw}, 16'h0001);

    // R3 break position and kind sweep
    for (int p = 1; p <= 7; p++) begin
      for (int k = 0; k < 3; k++) begin
        clean();
        send_qual(p);
        send_os(k == 1, k == 0);
        send_qual(7);
        chk($sformatf("R3 break p%0d k%0d seven", p, k), {15'b0, sts_auto_bw}, 16'h0000);
        send_qual(1);
        chk($sformatf("R3 break p%0d k%0d eight", p, k), {15'b0, sts_auto_bw}, 16'h0001);
      end
    end

    // R4 change reports sorted by cause
    clean();
    chg_valid = 1; chg_auto = 1; tick(); idle();
    chk("R4 auto change", rd_data, 16'h9000);
    clean();
    chg_valid = 1; chg_auto = 0; tick(); idle();
    chk("R4 mgmt change", rd_data, 16'h5000);

    // R5 retrain, R6 corrective change
    clean();
    retrain_wr = 1; tick(); idle();
    chk("R5 retrain", rd_data, 16'h5000);
    clean();
    fix_chg = 1; tick(); idle();
    chk("R6 fix change", rd_data, 16'h5000);

    // R7 write-1-to-clear rules
    clean();
    chg_valid = 1; chg_auto = 1; tick();
    chg_auto = 0; tick(); idle();
    chk("R7 both set", rd_data, 16'hD000);
    wr(RA, 2'b01, 16'hC000);
    chk("R7 low enable only", rd_data, 16'hD000);
    wr(12'h0B0, 2'b11, 16'hC000);
    chk("R7 other address", rd_data, 16'hD000);
    wr(RA, 2'b11, 16'h0000);
    chk("R7 zero data", rd_data, 16'hD000);
    tick(); tick();
    chk("R7 sticky hold", rd_data, 16'hD000);
    wr(RA, 2'b10, 16'h8000);
    chk("R7 clear bit15", rd_data, 16'h5000);
    wr(RA, 2'b11, 16'h4000);
    chk("R7 clear bit14", rd_data, 16'h1000);

    // R8 set wins over clear in the same cycle
    clean();
    chg_valid = 1; chg_auto = 0; tick(); idle();
    chg_valid = 1; chg_auto = 1;
    wr_en = 1; wr_addr = RA; wr_be = 2'b11; wr_data = 16'hC000;
    tick(); idle();
    chk("R8 change vs clear", rd_data, 16'h9000);
    retrain_wr = 1;
    wr_en = 1; wr_addr = RA; wr_be = 2'b11; wr_data = 16'hC000;
    tick(); idle();
    chk("R8 retrain vs clear", rd_data, 16'h5000);
    clean();
    send_qual(7);
    os_valid = 1; os_is_ts = 1; os_auto = 1;
    wr_en = 1; wr_addr = RA; wr_be = 2'b11; wr_data = 16'h8000;
    tick(); idle();
    chk("R8 run vs clear", {15'b0, sts_auto_bw}, 16'h0001);

    // R9 link-down suppression
    clean();
    dl_down = 1;
    chg_valid = 1; chg_auto = 1; tick();
    chg_auto = 0; tick(); idle();
    retrain_wr = 1; fix_chg = 1; tick(); idle();
    dl_down = 0;
    chk("R9 sources blocked", rd_data, 16'h1000);
    clean();
    send_qual(5);
    dl_down = 1; tick(); dl_down = 0;
    send_qual(3);
    chk("R9 run restarted", {15'b0, sts_auto_bw}, 16'h0000);
    clean();
    send_qual(7);
    dl_down = 1; send_qual(1); dl_down = 0;
    send_qual(1);
    chk("R9 set not counted", {15'b0, sts_auto_bw}, 16'h0000);
    send_qual(7);
    chk("R9 fresh run", {15'b0, sts_auto_bw}, 16'h0001);

    // pseudo-random sweep against an arithmetic model
    idle();
    rst = 1; tick(); rst = 0;
    e15 = 0; e14 = 0; edl = 0; run = 0;
    for (int c = 0; c < 3000; c++) begin
      ov = ($urandom % 8) != 0;
      ts = ($urandom % 16) != 0;
      au = ($urandom % 16) != 0;
      cv = ($urandom % 24) == 0;
      ca = $urandom % 2;
      fx = ($urandom % 40) == 0;
      rt = ($urandom % 40) == 0;
      dd = ($urandom % 60) == 0;
      da = ($urandom % 4) != 0;
      we = ($urandom % 6) == 0;
      ad = ($urandom % 3 == 0) ? 12'h0B3 : RA;
      be = $urandom % 4;
      wd = $urandom;
      os_valid = ov; os_is_ts = ts; os_auto = au;
      chg_valid = cv; chg_auto = ca; fix_chg = fx; retrain_wr = rt;
      dl_down = dd; dl_active = da;
      wr_en = we; wr_addr = ad; wr_be = be; wr_data = wd;
      s15 = !dd && ((ov && ts && au && run == 7) || (cv && ca));
      s14 = !dd && (rt || fx || (cv && !ca));
      c15 = we && ad == RA && be[1] && wd[15];
      c14 = we && ad == RA && be[1] && wd[14];
      if (dd) run = 0;
      else if (ov) run = (ts && au) ? ((run < 8) ? run + 1 : 8) : 0;
      e15 = s15 ? 1'b1 : (c15 ? 1'b0 : e15);
      e14 = s14 ? 1'b1 : (c14 ? 1'b0 : e14);
      edl = da;
      tick();
      chk("R2 sweep bit15", {15'b0, rd_data[15]}, {15'b0, e15});
      chk("R4 sweep bit14", {15'b0, rd_data[14]}, {15'b0, e14});
      chk("R10 sweep low bits", {3'b0, rd_data[12:0]}, 16'h1000);
      chk("R10 sweep link", {15'b0, rd_data[13]}, {15'b0, edl});
    end
    idle();
    dl_down = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule